// File: doc/BRIEF.md
# Three-Style Host Bus Slave

This block lets an external microprocessor read and write a small bank of 8-bit registers through one set of shared pins whose meaning changes with a mode select input. Three bus styles are offered: an asynchronous multiplexed style in which an address latch enable opens each cycle and separate active-low read and write strobes move the data; an asynchronous style with an active-low address strobe, a data strobe and a read/write direction pin; and a synchronous style in which the host drives its signals relative to the block clock, which then acts as the processor clock.

In the two asynchronous styles every host input passes through a two-flop synchronizer. Edge detection on the synchronized strobes turns each strobe into exactly one internal register action. In the synchronous style the pins are used directly, and a write lands in the register on the very clock edge that samples it. The bidirectional data bus is split into `data_in`, `data_out` and an output enable, and the pad cell is left to the chip top.

Top module: `hostbus_if`

## Requirements
- R1: After reset all sixteen registers read zero and `data_oe` is low.
- R2: `mode_sel` encodes the bus style: 0 is the latch-enable style, 1 is the address/data strobe style, 2 is the synchronous style, and 3 performs no transfer.
- R3: In mode 0 the address is the value on `addr` when `ale_as` falls. While `cs_n` and `strb_n` are both low, `data_oe` goes high within four clock cycles and `data_out` carries the addressed register. Within four cycles after `strb_n` rises, `data_oe` is low again.
- R4: In mode 0, `wr_rw` is an active-low write strobe. Its falling edge with `cs_n` low writes `data_in` into the latched address, exactly once for each strobe.
- R5: In mode 1 the address is the value on `addr` when `ale_as` rises (the address strobe deasserts). The value present when it fell is not used.
- R6: In mode 1, `wr_rw` high selects a read, and the register is driven while `cs_n` and `strb_n` are low. `wr_rw` low selects a write, which commits once on the falling edge of `strb_n` with `cs_n` low.
- R7: In mode 2, on a rising `clk` edge where `cs_n`, `strb_n` and `wr_rw` are all low, `data_in` is written to the register at `addr` on that same edge.
- R8: In mode 2, a `clk` edge that samples `cs_n` low and `wr_rw` high makes `data_oe` high and `data_out` equal to the register at the sampled `addr`, from that edge until the next one.
- R9: In mode 2, `ale_as` has no effect. The address latched for mode 0 is unchanged by any activity on it.
- R10: `data_oe` is never high during or directly after a write action, and it is low whenever no read is selected. While `data_oe` is low, `data_out` is zero.
- R11: Only addresses with `addr[14:4]` equal to zero are mapped, and `addr[3:0]` selects the register. A read of any other address returns zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the processor clock in mode 2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Bus style select |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address latch enable (mode 0) or address strobe (mode 1) |
| strb_n | input | 1 | Read strobe, data strobe or write enable, depending on the mode |
| wr_rw | input | 1 | Write strobe (mode 0), read/write direction (modes 1 and 2) |
| addr | input | 15 | Host address |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Read data toward the host |
| data_oe | output | 1 | Enable for the external data driver |

## Verification
The assertions assume that `mode_sel` changes only while the bus is idle, and that a host never asserts the read strobe and the write strobe of mode 0 together. They also assume that, in the asynchronous styles, `addr`, `data_in` and the direction pin settle several clock cycles before the strobe that uses them. The bench keeps to these conditions. It changes mode only inside a task that first returns every pin to its idle level for that style. It holds address and data for at least three cycles around every strobe edge. Random draws select only the mode, direction, address and data, and never the timing of the pins.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        HB_MODE_ALE    = 2'd0,
        HB_MODE_STROBE = 2'd1,
        HB_MODE_SYNC   = 2'd2,
        HB_MODE_NONE   = 2'd3
    } hb_mode_e;

    localparam int HB_CTRL_BITS = 4;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int AW   = 15,
    parameter int DW   = 8,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_mapped
);
    localparam int IW = $clog2(NREG);

    logic [DW-1:0] regs_q [NREG];
    logic          wr_mapped;

    assign wr_mapped = (wr_addr[AW-1:IW] == '0);
    assign rd_mapped = (rd_addr[AW-1:IW] == '0);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && wr_mapped && (wr_addr[IW-1:0] == IW'(i)))
                regs_q[i] <= wr_data;
        end
    end

    assign rd_data = rd_mapped ? regs_q[rd_addr[IW-1:0]] : '0;
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hb_pkg::*;
#(
    parameter int AW     = 15,
    parameter int DW     = 8,
    parameter int NREG   = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          cs_n,
    input  logic          ale_as,
    input  logic          strb_n,
    input  logic          wr_rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe
);
    localparam int SW = HB_CTRL_BITS + AW + DW;
    localparam logic [SW-1:0] SYNC_RST = {{HB_CTRL_BITS{1'b1}}, {(AW + DW){1'b0}}};

    typedef struct packed {
        logic [AW-1:0] lat_addr;
        logic          oe;
        logic [DW-1:0] dout;
        logic          ale_p;
        logic          strb_p;
        logic          rw_p;
    } state_t;

    state_t        st_d, st_q;
    hb_mode_e      mode;
    logic [SW-1:0] sync_out;
    logic          s_cs_n, s_ale, s_strb, s_rw;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;
    logic          wr_en, rd_req, rd_mapped;
    logic [AW-1:0] wr_addr, rd_addr, lat_addr_q;
    logic [DW-1:0] wr_data, rd_data;

    assign mode = hb_mode_e'(mode_sel);

    hb_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, ale_as, strb_n, wr_rw, addr, data_in}),
        .q     (sync_out)
    );

    assign {s_cs_n, s_ale, s_strb, s_rw, s_addr, s_din} = sync_out;

    hb_regfile #(.AW(AW), .DW(DW), .NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_mapped (rd_mapped)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ale_p  = s_ale;
        st_d.strb_p = s_strb;
        st_d.rw_p   = s_rw;
        wr_en       = 1'b0;
        rd_req      = 1'b0;
        wr_addr     = st_q.lat_addr;
        rd_addr     = st_q.lat_addr;
        wr_data     = s_din;
        case (mode)
            HB_MODE_ALE: begin
                // address taken as the latch enable drops
                if (st_q.ale_p && !s_ale) st_d.lat_addr = s_addr;
                rd_req = !s_cs_n && !s_strb;
                wr_en  = !s_cs_n && st_q.rw_p && !s_rw;
            end
            HB_MODE_STROBE: begin
                // address taken as the address strobe releases
                if (!st_q.ale_p && s_ale) st_d.lat_addr = s_addr;
                rd_req = !s_cs_n && !s_strb && s_rw;
                wr_en  = !s_cs_n && st_q.strb_p && !s_strb && !s_rw;
            end
            HB_MODE_SYNC: begin
                rd_addr = addr;
                wr_addr = addr;
                wr_data = data_in;
                rd_req  = !cs_n && wr_rw;
                wr_en   = !cs_n && !strb_n && !wr_rw;
            end
            default: ;
        endcase
        st_d.oe   = rd_req && !wr_en;
        st_d.dout = st_d.oe ? rd_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ale_p    <= 1'b1;
            st_q.strb_p   <= 1'b1;
            st_q.rw_p     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_addr_q = st_q.lat_addr;
    assign data_oe    = st_q.oe;
    assign data_out   = st_q.dout;
endmodule

// File: rtl/hostbus_if_chk.sv
module hostbus_if_chk #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_sel,
    input logic          wr_en,
    input logic          rd_mapped,
    input logic          data_oe,
    input logic [DW-1:0] data_out,
    input logic [AW-1:0] lat_addr_q
);
    // R4: an asynchronous strobe yields a single write pulse
    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_sel != 2'd2) |=> !wr_en);

    // R10: no drive in the cycle after a write action
    a_r10_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !data_oe);

    // R10: idle bus carries zero data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0);

    // R11: unmapped reads return zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && !$past(rd_mapped)) |-> data_out == '0);

    // R9: latched address frozen in synchronous mode
    a_r9_sync_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2) |=> $stable(lat_addr_q));
endmodule

bind hostbus_if hostbus_if_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .wr_en      (wr_en),
    .rd_mapped  (rd_mapped),
    .data_oe    (data_oe),
    .data_out   (data_out),
    .lat_addr_q (lat_addr_q)
);

// File: tb/test_hostbus_if.sv
module test_hostbus_if;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd2;
    logic        cs_n = 1'b1, ale_as = 1'b0, strb_n = 1'b1, wr_rw = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hostbus_if i_hostbus_if (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
        .ale_as(ale_as), .strb_n(strb_n), .wr_rw(wr_rw), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic [7:0] exp_read(logic [14:0] a);
        return (a[14:4] == 0) ? model[a[3:0]] : 8'h00;
    endfunction

    function automatic void note_write(logic [14:0] a, logic [7:0] d);
        if (a[14:4] == 0) model[a[3:0]] = d;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        cs_n = 1'b1; strb_n = 1'b1; wr_rw = 1'b1;
        ale_as = (m == 2'd1);
        cyc(4);
        mode_sel = m;
        cyc(4);
    endtask

    // address phase for the asynchronous styles: a0 while asserted, a1 at release
    task automatic addr_phase(logic [1:0] m, logic [14:0] a0, logic [14:0] a1);
        addr = a0; ale_as = (m == 2'd0); cyc(3);
        addr = a1; cyc(3);
        ale_as = (m == 2'd1); cyc(4);
    endtask

    task automatic a_write(logic [14:0] a, logic [7:0] d);
        addr_phase(2'd0, a, a);
        cs_n = 1'b0; data_in = d; cyc(3);
        wr_rw = 1'b0; cyc(2);
        chk("R10 oe during mode0 write", data_oe, 0);
        cyc(3); wr_rw = 1'b1; cyc(4); cs_n = 1'b1; cyc(2);
        note_write(a, d);
    endtask

    task automatic a_read(logic [14:0] a0, logic [14:0] a1, string req);
        addr_phase(2'd0, a0, a1);
        cs_n = 1'b0; strb_n = 1'b0; cyc(4);
        chk({req, " oe"}, data_oe, 1);
        chk({req, " data"}, data_out, exp_read(a1));
        strb_n = 1'b1; cs_n = 1'b1; cyc(4);
        chk({req, " release"}, data_oe, 0);
    endtask

    task automatic b_write(logic [14:0] a, logic [7:0] d);
        addr_phase(2'd1, a, a);
        cs_n = 1'b0; wr_rw = 1'b0; data_in = d; cyc(3);
        strb_n = 1'b0; cyc(2);
        chk("R10 oe during mode1 write", data_oe, 0);
        cyc(3); strb_n = 1'b1; cyc(4); cs_n = 1'b1; wr_rw = 1'b1; cyc(2);
        note_write(a, d);
    endtask

    task automatic b_read(logic [14:0] a0, logic [14:0] a1, string req);
        addr_phase(2'd1, a0, a1);
        cs_n = 1'b0; wr_rw = 1'b1; cyc(3);
        strb_n = 1'b0; cyc(4);
        chk({req, " oe"}, data_oe, 1);
        chk({req, " data"}, data_out, exp_read(a1));
        strb_n = 1'b1; cs_n = 1'b1; cyc(4);
        chk({req, " release"}, data_oe, 0);
    endtask

    task automatic c_write(logic [14:0] a, logic [7:0] d);
        cs_n = 1'b0; strb_n = 1'b0; wr_rw = 1'b0; addr = a; data_in = d;
        @(negedge clk);
        chk("R10 oe after mode2 write", data_oe, 0);
        cs_n = 1'b1; strb_n = 1'b1; wr_rw = 1'b1;
        note_write(a, d);
    endtask

    task automatic c_read(logic [14:0] a, string req);
        cs_n = 1'b0; wr_rw = 1'b1; addr = a;
        @(negedge clk);
        chk({req, " oe"}, data_oe, 1);
        chk({req, " data"}, data_out, exp_read(a));
        cs_n = 1'b1;
        @(negedge clk);
        chk("R10 oe idle", data_oe, 0);
        chk("R10 data idle", data_out, 0);
    endtask

    function automatic logic [14:0] rand_addr();
        if ($urandom % 2) return {11'd0, 4'($urandom)};
        return 15'($urandom) | 15'h0010;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] cur;
        void'($urandom(32'd7331));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 oe after reset", data_oe, 0);
        for (int i = 0; i < 16; i++) c_read(15'(i), "R1 reset value");

        // R7 same-edge write, R8 read, back to back
        c_write(15'd3, 8'hA5);
        c_read(15'd3, "R7 mode2 write");
        c_write(15'd15, 8'h3C);
        c_read(15'd15, "R8 mode2 read");
        // R11 unmapped write dropped, read zero
        c_write(15'h0013, 8'hEE);
        c_read(15'd3, "R11 unmapped write alias");
        c_read(15'h0013, "R11 unmapped read");
        c_read(15'h4000, "R11 unmapped top");

        // R3/R4 mode 0 with address taken at falling latch enable
        set_mode(2'd0);
        a_write(15'd5, 8'h5A);
        a_read(15'd9, 15'd5, "R3 mode0 read");
        a_write(15'h0105, 8'h11);
        a_read(15'd5, 15'd5, "R11 mode0 unmapped write");

        // R9: latch enable activity in mode 2 changes nothing
        set_mode(2'd2);
        addr = 15'd9; ale_as = 1'b1; cyc(4); ale_as = 1'b0; cyc(4);
        set_mode(2'd0);
        cs_n = 1'b0; strb_n = 1'b0; cyc(4);
        chk("R9 latched addr kept", data_out, exp_read(15'd5));
        strb_n = 1'b1; cs_n = 1'b1; cyc(4);

        // R5/R6 mode 1, address taken at strobe release
        set_mode(2'd1);
        b_write(15'd9, 8'hC3);
        b_read(15'd3, 15'd9, "R5 mode1 addr at rise");
        b_read(15'd9, 15'd3, "R6 mode1 read");

        // R2: code 3 performs nothing
        set_mode(2'd3);
        cs_n = 1'b0; strb_n = 1'b0; wr_rw = 1'b0; addr = 15'd9; data_in = 8'hFF;
        cyc(6);
        chk("R2 mode3 no drive", data_oe, 0);
        cs_n = 1'b1; strb_n = 1'b1; wr_rw = 1'b1;
        set_mode(2'd2);
        c_read(15'd9, "R2 mode3 no write");

        cur = 2'd2;
        for (int i = 0; i < 80; i++) begin
            logic [1:0]  m;
            logic [14:0] a;
            logic [7:0]  d;
            m = 2'($urandom % 3);
            a = rand_addr();
            d = 8'($urandom);
            if (m != cur) begin
                set_mode(m);
                cur = m;
            end
            case (m)
                2'd0: if ($urandom % 2) a_write(a, d); else a_read(a, a, "R3 random");
                2'd1: if ($urandom % 2) b_write(a, d); else b_read(a, a, "R6 random");
                default: if ($urandom % 2) c_write(a, d); else c_read(a, "R8 random");
            endcase
        end

        set_mode(2'd2);
        for (int i = 0; i < 16; i++) c_read(15'(i), "R4 R6 R7 final contents");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule